// File: doc/BRIEF.md
# Framebuffer Rectangle Copy Engine

This block moves a rectangular region of a 1024x512 framebuffer of 16-bit pixels to another place in the same framebuffer. A single start strobe hands it three command words: a source corner, a destination corner and a size. The engine then works through the rectangle one row at a time, in chunks of up to 128 pixels. Each chunk is first read completely into a local staging buffer and only then written back. Because of this ordering, a source and destination that overlap inside a chunk still copy correctly.

Source and destination coordinates wrap on their own: columns modulo 1024 and rows modulo 512. An optional force-mask input sets the top bit of every pixel written. When the source and destination corners are equal and the force-mask input is clear, the copy would change nothing. In that case the engine does not touch memory and reports completion on the next cycle.

The framebuffer is reached through a single synchronous RAM port with one access per cycle. The same port serves the read and write phases.

Top module: `fb_rect_copy`

## Requirements
- R1: A corner word gives the column in bits 9:0 and the row in bits 24:16. All other bits are ignored. This holds for both the source word and the destination word.
- R2: The size word gives the width in bits 9:0 and the height in bits 24:16. A zero field means the full extent: 1024 columns or 512 rows. Any other field value is used as is.
- R3: Pixel (x, y) sits at RAM address y*1024 + x. The source and destination column and row each wrap separately: columns modulo 1024, rows modulo 512.
- R4: A row is handled in chunks of min(128, remaining width) pixels. Each chunk issues its reads on consecutive cycles, then leaves the port idle for one cycle, then issues its writes on consecutive cycles, in the same pixel order as the reads.
- R5: Rows are copied in increasing row offset. Within a row, chunks and the pixels inside them are copied in increasing column offset.
- R6: When the force-mask input is 1 at start, every written pixel is the read pixel with bit 15 set. When it is 0, the written pixel equals the read pixel.
- R7: When the decoded source corner equals the destination corner and force-mask is 0, the port is never enabled. Busy stays low, and done is high on the cycle after start.
- R8: Busy is high from the cycle after an accepted start through the cycle of the last write. Done is high for exactly the one cycle after that last write.
- R9: A start asserted while busy is ignored. The running copy continues unchanged.
- R10: After reset, busy, done and the RAM enable are low.
- R11: A destination that overlaps its source within one chunk receives the source pixels as they were before that chunk's writes began.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a copy with the words below (ignored while busy) |
| src_pos | input | 32 | Source corner word |
| dst_pos | input | 32 | Destination corner word |
| size_word | input | 32 | Width and height word |
| mask_set | input | 1 | Force bit 15 on in written pixels |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_en | output | 1 | RAM access this cycle |
| mem_we | output | 1 | Access is a write (read when 0) |
| mem_addr | output | 19 | Pixel address, row*1024 + column |
| mem_wdata | output | 16 | Write pixel |
| mem_rdata | input | 16 | Read pixel, valid the cycle after a read access |

## Verification
The hardest case to reach is a rectangle that crosses a chunk boundary and also wraps at the framebuffer edge and overlaps its own destination. In that case the order of reads and writes decides the result. The stimulus places rectangles near column 1023 and row 511, uses widths above 128, and shifts the destination a few pixels to the right of the source. The full-extent size decodes get their own runs: one with a zero width field and one with a zero height field. The bench model replays the chunked semantics against a shadow copy of memory and predicts every port access cycle by cycle.

// File: rtl/fbc_pkg.sv
package fbc_pkg;
  localparam int FBC_XW = 10;
  localparam int FBC_YW = 9;
  localparam int FBC_PW = 16;
  localparam int FBC_CH = 128;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_TURN = 2'd2,
    ST_WR   = 2'd3
  } fbc_state_t;
endpackage

// File: rtl/fbc_decode.sv
module fbc_decode #(
  parameter int XW = fbc_pkg::FBC_XW,
  parameter int YW = fbc_pkg::FBC_YW,
  parameter int WW = 32
) (
  input  logic [WW-1:0] src_pos,
  input  logic [WW-1:0] dst_pos,
  input  logic [WW-1:0] size_word,
  input  logic          mask_set,
  output logic [XW-1:0] sx,
  output logic [YW-1:0] sy,
  output logic [XW-1:0] dx,
  output logic [YW-1:0] dy,
  output logic [XW:0]   w,
  output logic [YW:0]   h,
  output logic          noop
);
  localparam int YLSB = 16;

  // zero field stands for the full extent
  function automatic logic [XW:0] len_x(input logic [XW-1:0] f);
    len_x = (f == '0) ? {1'b1, {XW{1'b0}}} : {1'b0, f};
  endfunction

  function automatic logic [YW:0] len_y(input logic [YW-1:0] f);
    len_y = (f == '0) ? {1'b1, {YW{1'b0}}} : {1'b0, f};
  endfunction

  assign sx = src_pos[XW-1:0];
  assign sy = src_pos[YLSB +: YW];
  assign dx = dst_pos[XW-1:0];
  assign dy = dst_pos[YLSB +: YW];
  assign w  = len_x(size_word[XW-1:0]);
  assign h  = len_y(size_word[YLSB +: YW]);
  assign noop = (sx == dx) && (sy == dy) && !mask_set;

  logic unused_bits;
  assign unused_bits = ^{src_pos, dst_pos, size_word};
endmodule

// File: rtl/fbc_linebuf.sv
module fbc_linebuf #(
  parameter int PW = fbc_pkg::FBC_PW,
  parameter int CH = fbc_pkg::FBC_CH,
  localparam int CW = $clog2(CH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_idx,
  input  logic [PW-1:0] wr_data,
  input  logic [CW-1:0] rd_idx,
  output logic [PW-1:0] rd_data
);
  logic [PW-1:0] stage [CH];

  always_ff @(posedge clk) begin
    if (wr_en) stage[wr_idx] <= wr_data;
  end

  assign rd_data = stage[rd_idx];
endmodule

// File: rtl/fbc_seq.sv
module fbc_seq
  import fbc_pkg::*;
#(
  parameter int XW = FBC_XW,
  parameter int YW = FBC_YW,
  parameter int CH = FBC_CH,
  localparam int CW = $clog2(CH),
  localparam int AW = XW + YW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          noop,
  input  logic [XW-1:0] sx,
  input  logic [YW-1:0] sy,
  input  logic [XW-1:0] dx,
  input  logic [YW-1:0] dy,
  input  logic [XW:0]   w,
  input  logic [YW:0]   h,
  input  logic          mask_in,
  output logic          busy,
  output logic          done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          wr_mask,
  output logic          cap_we,
  output logic [CW-1:0] cap_idx,
  output logic [CW-1:0] rd_idx
);
  fbc_state_t    state_q;
  logic [XW-1:0] sx_q, dx_q, xoff_q;
  logic [YW-1:0] sy_q, dy_q, row_q;
  logic [XW:0]   w_q;
  logic [YW:0]   h_q;
  logic          msk_q, done_q, cap_v_q;
  logic [CW-1:0] idx_q, cap_idx_q;

  // chunk length and end-of-chunk/row/rect events
  logic [XW:0]   rem;
  logic [CW:0]   cl;
  logic          chunk_last, row_last_chunk, rect_last_row;
  logic [XW-1:0] rx, wx;
  logic [YW-1:0] ry, wy;

  assign rem            = w_q - {1'b0, xoff_q};
  assign cl             = (rem > (XW+1)'(CH)) ? (CW+1)'(CH) : rem[CW:0];
  assign chunk_last     = ({1'b0, idx_q} == cl - 1'b1);
  assign row_last_chunk = ({1'b0, xoff_q} + (XW+1)'(cl) == w_q);
  assign rect_last_row  = ({1'b0, row_q} == h_q - 1'b1);

  assign rx = sx_q + xoff_q + XW'(idx_q);
  assign wx = dx_q + xoff_q + XW'(idx_q);
  assign ry = sy_q + row_q;
  assign wy = dy_q + row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sx_q <= '0; sy_q <= '0; dx_q <= '0; dy_q <= '0;
      w_q <= '0; h_q <= '0; msk_q <= 1'b0;
      xoff_q <= '0; row_q <= '0; idx_q <= '0;
      done_q <= 1'b0; cap_v_q <= 1'b0; cap_idx_q <= '0;
    end else begin
      done_q    <= 1'b0;
      cap_v_q   <= (state_q == ST_RD);
      cap_idx_q <= idx_q;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (noop) begin
              done_q <= 1'b1;
            end else begin
              sx_q <= sx; sy_q <= sy; dx_q <= dx; dy_q <= dy;
              w_q <= w; h_q <= h; msk_q <= mask_in;
              xoff_q <= '0; row_q <= '0; idx_q <= '0;
              state_q <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (chunk_last) begin
            idx_q   <= '0;
            state_q <= ST_TURN;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_TURN: state_q <= ST_WR;
        ST_WR: begin
          if (chunk_last) begin
            idx_q <= '0;
            if (!row_last_chunk) begin
              xoff_q  <= xoff_q + XW'(cl);
              state_q <= ST_RD;
            end else if (!rect_last_row) begin
              xoff_q  <= '0;
              row_q   <= row_q + 1'b1;
              state_q <= ST_RD;
            end else begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign mem_en   = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_we   = (state_q == ST_WR);
  assign mem_addr = mem_we ? {wy, wx} : {ry, rx};
  assign wr_mask  = msk_q;
  assign cap_we   = cap_v_q;
  assign cap_idx  = cap_idx_q;
  assign rd_idx   = idx_q;

  // R4: the port never goes straight from a read to a write
  p_turn_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && !mem_we) |=> !(mem_en && mem_we));

  // R8: done is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: busy only ends together with done
  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R9: a start while busy leaves the latched command untouched
  p_hold_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(w_q) && $stable(h_q) && $stable(sx_q) && $stable(dx_q)));
endmodule

// File: rtl/fb_rect_copy.sv
module fb_rect_copy #(
  parameter int XW = fbc_pkg::FBC_XW,
  parameter int YW = fbc_pkg::FBC_YW,
  parameter int PW = fbc_pkg::FBC_PW,
  parameter int CH = fbc_pkg::FBC_CH,
  parameter int WW = 32,
  localparam int CW = $clog2(CH),
  localparam int AW = XW + YW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [WW-1:0] src_pos,
  input  logic [WW-1:0] dst_pos,
  input  logic [WW-1:0] size_word,
  input  logic          mask_set,
  output logic          busy,
  output logic          done,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [PW-1:0] mem_wdata,
  input  logic [PW-1:0] mem_rdata
);
  logic [XW-1:0] sx, dx;
  logic [YW-1:0] sy, dy;
  logic [XW:0]   w;
  logic [YW:0]   h;
  logic          noop, wr_mask, cap_we;
  logic [CW-1:0] cap_idx, rd_idx;
  logic [PW-1:0] stage_px;

  fbc_decode #(.XW(XW), .YW(YW), .WW(WW)) u_dec (
    .src_pos(src_pos), .dst_pos(dst_pos), .size_word(size_word),
    .mask_set(mask_set), .sx(sx), .sy(sy), .dx(dx), .dy(dy),
    .w(w), .h(h), .noop(noop)
  );

  fbc_seq #(.XW(XW), .YW(YW), .CH(CH)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .noop(noop),
    .sx(sx), .sy(sy), .dx(dx), .dy(dy), .w(w), .h(h), .mask_in(mask_set),
    .busy(busy), .done(done), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .wr_mask(wr_mask), .cap_we(cap_we),
    .cap_idx(cap_idx), .rd_idx(rd_idx)
  );

  fbc_linebuf #(.PW(PW), .CH(CH)) u_buf (
    .clk(clk), .wr_en(cap_we), .wr_idx(cap_idx), .wr_data(mem_rdata),
    .rd_idx(rd_idx), .rd_data(stage_px)
  );

  assign mem_wdata = {stage_px[PW-1] | wr_mask, stage_px[PW-2:0]};

  // R6: forced mask shows on every written pixel
  p_mask_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_en && mem_we && wr_mask) |-> mem_wdata[PW-1]);

  // R7: a no-op command finishes next cycle without memory traffic
  p_noop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && noop) |=> (done && !busy && !mem_en));

  // R8: no port activity while idle
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_en);
endmodule

// File: tb/fb_rect_copy_test.sv
module fb_rect_copy_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] src_pos = '0, dst_pos = '0, size_word = '0;
  logic        mask_set = 1'b0;
  logic        busy, done, mem_en, mem_we;
  logic [18:0] mem_addr;
  logic [15:0] mem_wdata;
  logic [15:0] rdata_q = '0;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit wd_hit = 1'b0;

  always #4 clk = ~clk;

  fb_rect_copy uut (
    .clk(clk), .rst_n(rst_n), .start(start), .src_pos(src_pos),
    .dst_pos(dst_pos), .size_word(size_word), .mask_set(mask_set),
    .busy(busy), .done(done), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(rdata_q)
  );

  // sparse framebuffer model
  logic [15:0] ram [int];
  logic [15:0] shadow [int];

  function automatic logic [15:0] seed_px(int a);
    return 16'(((a * 40503) ^ (a >>> 3)) & 16'hFFFF);
  endfunction

  function automatic logic [15:0] ram_get(int a);
    if (ram.exists(a)) return ram[a];
    return seed_px(a);
  endfunction

  function automatic logic [15:0] sh_get(int a);
    if (shadow.exists(a)) return shadow[a];
    return seed_px(a);
  endfunction

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[int'(mem_addr)] = mem_wdata;
      else rdata_q <= ram_get(int'(mem_addr));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !wd_hit) begin
      wd_hit = 1'b1;
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  typedef struct {
    bit en;
    bit we;
    int addr;
    int data;
  } slot_t;
  slot_t exp_q[$];

  // behavioural model of the chunked copy on a shadow memory
  task automatic build_trace(int s, int d, int z, bit m, output bit is_noop);
    int sx = s & 1023, sy = (s >> 16) & 511;
    int dx = d & 1023, dy = (d >> 16) & 511;
    int w = ((z - 1) & 1023) + 1;
    int h = (((z >> 16) - 1) & 511) + 1;
    int stage[128];
    slot_t sl;
    shadow = ram;
    exp_q.delete();
    is_noop = (sx == dx) && (sy == dy) && !m;
    if (is_noop) return;
    for (int r = 0; r < h; r++) begin
      for (int xo = 0; xo < w; xo += 128) begin
        int cl = (w - xo > 128) ? 128 : w - xo;
        for (int i = 0; i < cl; i++) begin
          sl.en = 1; sl.we = 0; sl.data = 0;
          sl.addr = ((sy + r) & 511) * 1024 + ((sx + xo + i) & 1023);
          stage[i] = int'(sh_get(sl.addr));
          exp_q.push_back(sl);
        end
        sl.en = 0; sl.we = 0; sl.addr = 0; sl.data = 0;
        exp_q.push_back(sl);
        for (int i = 0; i < cl; i++) begin
          sl.en = 1; sl.we = 1;
          sl.addr = ((dy + r) & 511) * 1024 + ((dx + xo + i) & 1023);
          sl.data = stage[i] | (m ? 32'h8000 : 0);
          shadow[sl.addr] = 16'(sl.data);
          exp_q.push_back(sl);
        end
      end
    end
  endtask

  task automatic run_copy(int s, int d, int z, bit m, string req, int poke_at);
    bit is_noop;
    int n = 0;
    int bad = 0;
    bit first = 1'b1;
    @(negedge clk);
    build_trace(s, d, z, m, is_noop);
    src_pos = s; dst_pos = d; size_word = z; mask_set = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() > 0) begin
      slot_t e = exp_q.pop_front();
      bit ok = busy && !done && (mem_en == e.en) &&
               (!e.en || (mem_we == e.we && int'(mem_addr) == e.addr)) &&
               (!(e.en && e.we) || int'(mem_wdata) == e.data);
      if (!ok && bad < 3) chk(ok, req, {busy, mem_en, mem_we, mem_addr, mem_wdata},
                              {1'b1, e.en, e.we, 19'(e.addr), 16'(e.data)});
      else if (ok && first) chk(ok, req, 0, 0);
      if (!ok) bad++;
      first = 1'b0;
      n++;
      if (n == poke_at) begin
        // R9: a second start during the copy must be ignored
        src_pos = 32'h0000_0000; dst_pos = 32'h0011_0022;
        size_word = 32'h0003_0003; mask_set = 1'b1; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(done && !busy && !mem_en, {req, " R8 done"}, {done, busy, mem_en}, 3'b100);
    @(negedge clk);
    chk(!done && !busy, {req, " R8 pulse"}, {done, busy}, 2'b00);
    bad = 0;
    foreach (shadow[k]) if (ram_get(k) != shadow[k]) bad++;
    chk(bad == 0, {req, " memory"}, bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_en, "R10", {busy, done, mem_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_en, "R10", {busy, done, mem_en}, 0);

    // R1 R2 R5: plain copy with junk in unused bits
    run_copy(32'h7E05_FC0A, 32'h4020_8100, 32'h0003_0004, 1'b0, "R1 R2 R5", 0);
    // R3: wrap in both axes for source and destination
    run_copy(32'h01FE_03FE, 32'h01FF_03FD, 32'h0004_0005, 1'b0, "R3", 0);
    // R4: width above chunk size
    run_copy(32'h0005_0010, 32'h0030_0200, 32'h0002_00C8, 1'b0, "R4", 0);
    // R11: destination shifted right, overlapping
    run_copy(32'h0040_0100, 32'h0040_0103, 32'h0002_0014, 1'b0, "R11", 0);
    // R6: force mask, including identical corners
    run_copy(32'h0008_0008, 32'h0050_0300, 32'h0002_0006, 1'b1, "R6", 0);
    run_copy(32'h0060_0060, 32'h0060_0060, 32'h0001_0004, 1'b1, "R6 same", 0);
    // R7: identical corners without mask is a no-op
    run_copy(32'h0123_0045, 32'h8123_FC45, 32'h0010_0010, 1'b0, "R7", 0);
    // R9: start pulse in the middle of a copy
    run_copy(32'h0002_0002, 32'h0090_0090, 32'h0002_0008, 1'b0, "R9", 3);
    // R2: zero width field means 1024, zero height field means 512
    run_copy(32'h0007_0005, 32'h0100_0009, 32'h0001_0000, 1'b0, "R2 w0", 0);
    run_copy(32'h0000_0011, 32'h0003_0222, 32'h0000_0001, 1'b0, "R2 h0", 0);
    // R3 R4 R11: wrapping overlapped copy spanning chunks
    run_copy(32'h01F0_0380, 32'h01F1_0384, 32'h0003_0096, 1'b1, "R3 R4 R11", 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule